// File: doc/BRIEF.md
# Serial Line Wakeup, Break and Bit-Time Detector

This block watches an already synchronized serial receive line while the bus is asleep and recognizes the start of a frame header. One counter measures every level of the line. Edges of the line restart it, and the count reached at an edge is the length of the level that just ended. A sequencer gives that single measurement three uses, one after another. First it finds a long low pulse that wakes the bus. Then it finds a longer low pulse, the break. Then it times the alternating sync pattern that follows the break.

The sync pattern is the byte 0x55 sent least significant bit first, with its start and stop bits. On the line this appears as ten alternating levels, each one bit time long and starting low. From the falling edge of the start bit, the block adds the next `SYNC_BITS` level widths and divides the total by `SYNC_BITS`. The result, rounded to nearest by default, is the bit period in clock ticks. It is presented on `bit_period` and marked by a one-cycle `baud_valid`. The block then waits for the next break. It needs a new wakeup only after reset or after the line has stayed high for `IDLE_TICKS` while it waits for a break.

Top module: `lin_hdr_detect`

## Requirements
- R1: After reset, `wake_pulse`, `brk_pulse`, `baud_valid` and `bit_period` are 0, and the block waits for a wakeup pulse.
- R2: A low width is the number of clock samples at which `rx_in` is 0, counted from the first low sample after a high one up to the first high sample that follows.
- R3: While waiting for wakeup, a low width strictly greater than `wake_thresh` raises `wake_pulse` for one cycle, in the cycle after the first high sample. The block then waits for a break.
- R4: While waiting for wakeup, a low width of at most `wake_thresh` raises no flag and leaves the block waiting for wakeup.
- R5: Break detection is armed only after a wakeup. While armed, a low width strictly greater than `brk_thresh` raises `brk_pulse` for one cycle, in the cycle after the first high sample.
- R6: While waiting for a break, a low width of at most `brk_thresh` raises no flag, and the block keeps waiting for a break without needing a new wakeup.
- R7: After a break, the widths of the `SYNC_BITS` levels that follow the first falling edge are added together. At the edge that ends the last of those levels, `bit_period` is loaded with the total divided by `SYNC_BITS`, and `baud_valid` is 1 for exactly the next cycle. `bit_period` changes at no other time.
- R8: After `baud_valid`, the block waits for a break, so a second header is detected without another wakeup.
- R9: The width counter saturates at 2^CW-1 and does not wrap. A low pulse longer than that is reported as 2^CW-1.
- R10: While the block waits for a break, a high level lasting `IDLE_TICKS` samples returns it to waiting for wakeup.
- R11: During the sync measurement, a level reaching the saturated width abandons the measurement without `baud_valid` and returns the block to waiting for a break.
- R12: With `ROUND`=1 the division rounds to nearest: (total + SYNC_BITS/2) / SYNC_BITS. With `ROUND`=0 it truncates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_in | input | 1 | Synchronized receive line, idle high |
| wake_thresh | input | CW | Wakeup low-width threshold in ticks |
| brk_thresh | input | CW | Break low-width threshold in ticks |
| wake_pulse | output | 1 | One-cycle wakeup indication |
| brk_pulse | output | 1 | One-cycle break indication |
| bit_period | output | CW | Measured bit time in ticks |
| baud_valid | output | 1 | One-cycle strobe: new `bit_period` |

## Verification
`wake_pulse` and `brk_pulse` are due exactly one cycle after the clock edge that samples the first high level ending the low pulse. `baud_valid` and the new `bit_period` are due one cycle after the edge that ends the last counted sync level. Idle and saturation returns show up only in how later pulses are classified. The bench model updates on the same rising edge as the design and compares all four outputs 1 ns after every edge. Per-phase event counts then confirm the ignored, boundary and timeout cases.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

   typedef enum logic [1:0] {
      ST_WAIT_WAKE = 2'd0,
      ST_WAIT_BRK  = 2'd1,
      ST_SYNC      = 2'd2
   } hdr_state_e;

endpackage

// File: rtl/lin_edge_det.sv
module lin_edge_det (
   input  logic clk,
   input  logic rst,
   input  logic rx_in,
   output logic fall,
   output logic rise,
   output logic edge_any
);
   logic rx_q;

   always_ff @(posedge clk) begin
      if (rst) rx_q <= 1'b1;
      else     rx_q <= rx_in;
   end

   assign fall     = rx_q & ~rx_in;
   assign rise     = ~rx_q & rx_in;
   assign edge_any = rx_q ^ rx_in;
endmodule

// File: rtl/lin_width_ctr.sv
module lin_width_ctr #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          restart,
   output logic [CW-1:0] cnt_q
);
   localparam logic [CW-1:0] CMAX = '1;

   always_ff @(posedge clk) begin
      if (rst)               cnt_q <= '0;
      else if (restart)      cnt_q <= CW'(1);
      else if (cnt_q != CMAX) cnt_q <= cnt_q + CW'(1);
   end
endmodule

// File: rtl/lin_sync_avg.sv
module lin_sync_avg #(
   parameter int CW        = 16,
   parameter int SYNC_BITS = 8,
   parameter bit ROUND     = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   input  logic          take,
   input  logic [CW-1:0] width,
   output logic          last,
   output logic [CW-1:0] period
);
   localparam int SH = $clog2(SYNC_BITS);
   localparam int SW = CW + SH + 1;
   localparam int IW = (SH > 0) ? SH : 1;

   logic [SW-1:0] sum_q;
   logic [SW-1:0] total;
   logic [IW-1:0] idx_q;

   assign total = sum_q + SW'(width);
   assign last  = take && (idx_q == IW'(SYNC_BITS - 1));

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         sum_q <= '0;
         idx_q <= '0;
      end else if (take) begin
         sum_q <= total;
         idx_q <= idx_q + IW'(1);
      end
   end

   generate
      if (ROUND) begin : g_round
         logic [SW-1:0] biased;
         assign biased = total + SW'(SYNC_BITS / 2);
         assign period = CW'(biased >> SH);
      end else begin : g_trunc
         assign period = CW'(total >> SH);
      end
   endgenerate
endmodule

// File: rtl/lin_hdr_fsm.sv
module lin_hdr_fsm
   import lin_hdr_pkg::*;
#(
   parameter int CW         = 16,
   parameter int IDLE_TICKS = 1000
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          rx_in,
   input  logic          fall,
   input  logic          rise,
   input  logic          edge_any,
   input  logic [CW-1:0] width,
   input  logic [CW-1:0] wake_thresh,
   input  logic [CW-1:0] brk_thresh,
   input  logic          last,
   input  logic [CW-1:0] avg,
   output logic          acc_clr,
   output logic          acc_take,
   output logic          wake_o,
   output logic          brk_o,
   output logic          valid_o,
   output logic [CW-1:0] period_o
);
   localparam logic [CW-1:0] CMAX   = '1;
   localparam logic [CW-1:0] IDLE_W = CW'(IDLE_TICKS);

   hdr_state_e st_q;
   logic       started_q;
   logic       saturated;

   assign saturated = !edge_any && (width == CMAX);
   assign acc_take  = (st_q == ST_SYNC) && started_q && edge_any;
   assign acc_clr   = !((st_q == ST_SYNC) && started_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q      <= ST_WAIT_WAKE;
         started_q <= 1'b0;
         wake_o    <= 1'b0;
         brk_o     <= 1'b0;
         valid_o   <= 1'b0;
         period_o  <= '0;
      end else begin
         wake_o  <= 1'b0;
         brk_o   <= 1'b0;
         valid_o <= 1'b0;
         case (st_q)
            ST_WAIT_WAKE: begin
               if (rise && (width > wake_thresh)) begin
                  wake_o <= 1'b1;
                  st_q   <= ST_WAIT_BRK;
               end
            end
            ST_WAIT_BRK: begin
               if (rise && (width > brk_thresh)) begin
                  brk_o     <= 1'b1;
                  st_q      <= ST_SYNC;
                  started_q <= 1'b0;
               end else if (rx_in && !edge_any && (width >= IDLE_W)) begin
                  st_q <= ST_WAIT_WAKE;
               end
            end
            ST_SYNC: begin
               if (!started_q) begin
                  if (fall)           started_q <= 1'b1;
                  else if (saturated) st_q      <= ST_WAIT_BRK;
               end else if (edge_any) begin
                  if (last) begin
                     period_o  <= avg;
                     valid_o   <= 1'b1;
                     st_q      <= ST_WAIT_BRK;
                     started_q <= 1'b0;
                  end
               end else if (saturated) begin
                  st_q      <= ST_WAIT_BRK;
                  started_q <= 1'b0;
               end
            end
            default: st_q <= ST_WAIT_WAKE;
         endcase
      end
   end
endmodule

// File: rtl/lin_hdr_detect.sv
module lin_hdr_detect #(
   parameter int CW         = 16,
   parameter int SYNC_BITS  = 8,
   parameter bit ROUND      = 1'b1,
   parameter int IDLE_TICKS = 1000
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          rx_in,
   input  logic [CW-1:0] wake_thresh,
   input  logic [CW-1:0] brk_thresh,
   output logic          wake_pulse,
   output logic          brk_pulse,
   output logic [CW-1:0] bit_period,
   output logic          baud_valid
);
   generate
      if (CW < 4) begin : g_bad_cw
         $error("CW must be at least 4");
      end
      if ((SYNC_BITS < 2) || ((SYNC_BITS & (SYNC_BITS - 1)) != 0)) begin : g_bad_bits
         $error("SYNC_BITS must be a power of two, 2 or more");
      end
      if ((IDLE_TICKS < 1) || (IDLE_TICKS >= (2 ** CW) - 1)) begin : g_bad_idle
         $error("IDLE_TICKS must lie between 1 and 2**CW-2");
      end
   endgenerate

   logic          fall;
   logic          rise;
   logic          edge_any;
   logic [CW-1:0] cnt_q;
   logic          acc_clr;
   logic          acc_take;
   logic          last;
   logic [CW-1:0] avg;

   lin_edge_det u_edge (
      .clk      (clk),
      .rst      (rst),
      .rx_in    (rx_in),
      .fall     (fall),
      .rise     (rise),
      .edge_any (edge_any)
   );

   lin_width_ctr #(.CW(CW)) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .restart (edge_any),
      .cnt_q   (cnt_q)
   );

   lin_sync_avg #(.CW(CW), .SYNC_BITS(SYNC_BITS), .ROUND(ROUND)) u_avg (
      .clk    (clk),
      .rst    (rst),
      .clr    (acc_clr),
      .take   (acc_take),
      .width  (cnt_q),
      .last   (last),
      .period (avg)
   );

   lin_hdr_fsm #(.CW(CW), .IDLE_TICKS(IDLE_TICKS)) u_fsm (
      .clk         (clk),
      .rst         (rst),
      .rx_in       (rx_in),
      .fall        (fall),
      .rise        (rise),
      .edge_any    (edge_any),
      .width       (cnt_q),
      .wake_thresh (wake_thresh),
      .brk_thresh  (brk_thresh),
      .last        (last),
      .avg         (avg),
      .acc_clr     (acc_clr),
      .acc_take    (acc_take),
      .wake_o      (wake_pulse),
      .brk_o       (brk_pulse),
      .valid_o     (baud_valid),
      .period_o    (bit_period)
   );
endmodule

// File: rtl/lin_hdr_detect_chk.sv
module lin_hdr_detect_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst,
   input logic          rx_in,
   input logic          edge_any,
   input logic [CW-1:0] cnt_q,
   input logic          wake_pulse,
   input logic          brk_pulse,
   input logic          baud_valid,
   input logic [CW-1:0] bit_period
);
   localparam logic [CW-1:0] CMAX = '1;

   AST_WAKE_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
      wake_pulse |-> ($past(rx_in) && !$past(rx_in, 2))); // R3
   AST_BRK_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
      brk_pulse |-> ($past(rx_in) && !$past(rx_in, 2))); // R5
   AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (rst)
      $countones({wake_pulse, brk_pulse, baud_valid}) <= 1); // R8
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      baud_valid |=> !baud_valid); // R7
   AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (rst)
      !baud_valid |-> $stable(bit_period)); // R7
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
      ((cnt_q == CMAX) && !edge_any) |=> (cnt_q == CMAX)); // R9
endmodule

bind lin_hdr_detect lin_hdr_detect_chk #(.CW(CW)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .rx_in      (rx_in),
   .edge_any   (edge_any),
   .cnt_q      (cnt_q),
   .wake_pulse (wake_pulse),
   .brk_pulse  (brk_pulse),
   .baud_valid (baud_valid),
   .bit_period (bit_period)
);

// File: tb/test_lin_hdr_detect.sv
`timescale 1ns/1ps
module test_lin_hdr_detect;
   localparam int CW   = 12;
   localparam int MAXW = 4095;
   localparam int IDLE = 1000;
   localparam int NB   = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          rx  = 1'b1;
   logic [CW-1:0] wth = 12'd50;
   logic [CW-1:0] bth = 12'd200;
   logic          wake_pulse, brk_pulse, baud_valid;
   logic [CW-1:0] bit_period;

   int nchk = 0, nfail = 0;
   int n_wake = 0, n_brk = 0, n_valid = 0;
   int last_period = 0;

   // reference model state
   int m_prev = 1, m_run = 0, m_st = 0, m_started = 0, m_idx = 0, m_sum = 0;
   int e_wake = 0, e_brk = 0, e_valid = 0, e_period = 0;

   always #2 clk = ~clk;

   lin_hdr_detect #(.CW(CW), .SYNC_BITS(NB), .ROUND(1'b1), .IDLE_TICKS(IDLE))
   i_lin_hdr_detect (
      .clk(clk), .rst(rst), .rx_in(rx), .wake_thresh(wth), .brk_thresh(bth),
      .wake_pulse(wake_pulse), .brk_pulse(brk_pulse),
      .bit_period(bit_period), .baud_valid(baud_valid)
   );

   task automatic chk(string req, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural model: 0 waits wakeup, 1 waits break, 2 times sync
   always @(posedge clk) begin
      if (rst) begin
         m_prev = 1; m_run = 0; m_st = 0; m_started = 0; m_idx = 0; m_sum = 0;
         e_wake = 0; e_brk = 0; e_valid = 0; e_period = 0;
      end else begin
         int lvl, w;
         bit chg;
         lvl = int'(rx);
         chg = (lvl != m_prev);
         w = m_run;
         e_wake = 0; e_brk = 0; e_valid = 0;
         if (m_st == 0) begin
            if (chg && lvl == 1 && w > int'(wth)) begin e_wake = 1; m_st = 1; end
         end else if (m_st == 1) begin
            if (chg && lvl == 1 && w > int'(bth)) begin e_brk = 1; m_st = 2; m_started = 0; end
            else if (!chg && lvl == 1 && w >= IDLE) m_st = 0;
         end else begin
            if (m_started == 0) begin
               if (chg && lvl == 0) begin m_started = 1; m_idx = 0; m_sum = 0; end
               else if (!chg && w == MAXW) m_st = 1;
            end else if (chg) begin
               m_sum += w; m_idx++;
               if (m_idx == NB) begin
                  e_period = (m_sum + NB / 2) / NB;
                  e_valid = 1; m_st = 1; m_started = 0;
               end
            end else if (w == MAXW) begin
               m_st = 1; m_started = 0;
            end
         end
         m_run = chg ? 1 : ((m_run + 1 > MAXW) ? MAXW : m_run + 1);
         m_prev = lvl;
      end
   end

   // compare 1 ns after each edge
   always @(posedge clk) begin
      #1;
      if (!rst) begin
         chk("R3 wake_pulse", int'(wake_pulse), e_wake);
         chk("R5 brk_pulse", int'(brk_pulse), e_brk);
         chk("R7 baud_valid", int'(baud_valid), e_valid);
         chk("R7 bit_period", int'(bit_period), e_period);
         if (wake_pulse) n_wake++;
         if (brk_pulse) n_brk++;
         if (baud_valid) begin n_valid++; last_period = int'(bit_period); end
      end
   end

   task automatic send(bit v, int n);
      rx = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_counts();
      n_wake = 0; n_brk = 0; n_valid = 0;
   endtask

   task automatic sync_uniform(int w);
      for (int i = 0; i < 9; i++) send((i % 2) != 0, w);
      send(1'b1, 40);
   endtask

   bit done = 1'b0;

   initial begin
      #(4 * 150000);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      // R1: reset values
      chk("R1 wake", int'(wake_pulse), 0);
      chk("R1 brk", int'(brk_pulse), 0);
      chk("R1 valid", int'(baud_valid), 0);
      chk("R1 period", int'(bit_period), 0);
      rst = 1'b0;
      send(1'b1, 20);

      // R2 R4: width equal to threshold is ignored
      clear_counts();
      send(1'b0, 50); send(1'b1, 30);
      chk("R4 no wake at threshold", n_wake, 0);
      // R2 R3: one more sample crosses it
      send(1'b0, 51); send(1'b1, 30);
      chk("R3 wake above threshold R2", n_wake, 1);

      // R6: short pulse while armed
      clear_counts();
      send(1'b0, 120); send(1'b1, 30);
      chk("R6 no brk short", n_brk, 0);
      chk("R6 no wake", n_wake, 0);
      send(1'b0, 201); send(1'b1, 25);
      chk("R5 brk", n_brk, 1);
      sync_uniform(20);
      chk("R7 valid count", n_valid, 1);
      chk("R7 period", last_period, 20);

      // R8 R12: second header, uneven widths sum 165 -> 21 rounded
      clear_counts();
      send(1'b0, 250); send(1'b1, 25);
      send(1'b0, 20); send(1'b1, 21); send(1'b0, 21); send(1'b1, 20);
      send(1'b0, 21); send(1'b1, 21); send(1'b0, 20); send(1'b1, 21);
      send(1'b0, 20); send(1'b1, 40);
      chk("R8 brk without wake", n_brk, 1);
      chk("R8 no wake", n_wake, 0);
      chk("R12 rounded period", last_period, 21);

      // R10: idle high returns to wakeup wait
      clear_counts();
      send(1'b1, 1010);
      send(1'b0, 250); send(1'b1, 30);
      chk("R10 wake after idle", n_wake, 1);
      chk("R10 no brk after idle", n_brk, 0);

      // R11: saturating level aborts sync
      clear_counts();
      send(1'b0, 250); send(1'b1, 25);
      send(1'b0, 4200); send(1'b1, 30);
      chk("R11 no valid", n_valid, 0);
      chk("R11 back to break wait", n_brk, 2);
      sync_uniform(20);
      chk("R8 valid after abort", n_valid, 1);

      // R9: saturation, not wrap (5000 mod 4096 would be short)
      wth = 12'd4094;
      clear_counts();
      send(1'b1, 1100);
      send(1'b0, 5000); send(1'b1, 30);
      chk("R9 saturated width wakes", n_wake, 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule